// File: doc/BRIEF.md
# Compressed Occurrence-Count Lookup

This block answers a pair of occurrence-count queries against a BWT whose counts are kept in external memory in compressed form. A caller supplies two positions, `k` and `k+s`. For each position the block returns how many times each base (A, C, G, T) appears in the BWT strictly before that position. It is the lookup engine behind one step of a backward/forward interval extension.

The table is stored as 256-bit blocks. Each block carries four 40-bit base counts and 32 packed 3-bit BWT symbols. A base count is the number of times that base occurs in every symbol of all earlier blocks, the terminator symbol included. To answer a query, the block fetches the block that contains the position. It then adds, for each base, the number of matching symbols that sit before the position's in-block offset. The two block reads go out over a simple address/data handshake. Decoding of the first block runs while the second read is still outstanding, and the two events may complete in either order. Both results are presented together with a one-cycle valid pulse.

Top module: `occ_block_lookup`

## Requirements
- R1: While reset is high and on the first cycle after it, `busy`, `occ_valid`, `ar_valid` and `r_ready` are low.
- R2: In a block, base counts sit at bits [39:0] for A, [79:40] for C, [119:80] for G and [159:120] for T. Symbol j (0..31) occupies bits [160+3j+2 : 160+3j].
- R3: Each query issues exactly two read requests, in order: first for the block holding `k`, then for the block holding `k+s`. The address is the 40-bit position with its low five bits cleared. The address is held stable while `ar_valid` waits for `ar_ready`.
- R4: The result for base b at position i is the block's base count for b plus the number of symbols equal to b at in-block offsets 0 to (i mod 32)-1. An offset of 0 returns the base count alone.
- R5: Only codes 100 (A), 101 (C), 110 (G) and 111 (T) are counted. Every code with the top bit clear, including 001 (terminator) and 000 (unknown), matches no base.
- R6: `occ_k_out` and `occ_ks_out` each hold four counts in element order 0=A, 1=C, 2=G, 3=T, for positions `k` and `k+s` respectively.
- R7: `occ_valid` is a single-cycle pulse raised as `busy` falls. Both outputs change only in that cycle and hold their values until the next pulse.
- R8: The second read may be accepted before the first block's data returns. The answer is correct whether the second block's data arrives before, with, or after the end of the first block's decode.
- R9: `start` is ignored while `busy` is high. A query's result depends only on the positions given with the `start` that launched it.
- R10: `r_ready` is high only while the block is busy and a block's data is still expected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Launch a query when idle |
| pos_k_in | input | ADDR_W | First query position (k) |
| pos_ks_in | input | ADDR_W | Second query position (k+s) |
| busy | output | 1 | Query in progress |
| occ_valid | output | 1 | One-cycle result pulse |
| occ_k_out | output | 4 x CNT_W | Counts before k, index 0=A..3=T |
| occ_ks_out | output | 4 x CNT_W | Counts before k+s, index 0=A..3=T |
| ar_valid | output | 1 | Read request valid |
| ar_ready | input | 1 | Read request accepted |
| ar_addr | output | ADDR_W | Byte address of the block to read |
| r_valid | input | 1 | Read data valid |
| r_ready | output | 1 | Read data accepted |
| r_data | input | BLK_W | One compressed block |

## Verification
The assertions take for granted that the memory returns read data in request order and never raises `r_valid` for a request it has not accepted. Under those conditions at most two reads are outstanding, and the data arriving in each fetch state belongs to the expected block. The bench's memory model keeps a two-entry ordered queue and accepts at most two requests. It returns each block only after its own request handshake, with a latency chosen per query so that the second block arrives both before and after the first decode ends. Stall patterns on `ar_ready` exercise the held-request rule.

// File: rtl/occ_lu_pkg.sv
package occ_lu_pkg;

    localparam int SYM_W  = 3;
    localparam int N_BASE = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREPARE,
        ST_READ1,
        ST_DEC1_RD2,
        ST_WAIT_RD2,
        ST_WAIT_DEC1,
        ST_DECOMP2
    } lu_state_e;

    // Base index 0..3 (A,C,G,T) maps to codes 100..111; top bit clear never matches.
    function automatic logic [SYM_W-1:0] base_code(input int unsigned idx);
        logic [1:0] low;
        low = idx[1:0];
        return {1'b1, low};
    endfunction

endpackage

// File: rtl/occ_base_counter.sv
module occ_base_counter
    import occ_lu_pkg::*;
#(
    parameter int CNT_W    = 40,
    parameter int SYMS     = 32,
    parameter int BASE_IDX = 0,
    localparam int OFF_W   = $clog2(SYMS),
    localparam int SLICE_W = SYMS * SYM_W
) (
    input  logic [SLICE_W-1:0] slice,
    input  logic [OFF_W-1:0]   offset,
    input  logic [CNT_W-1:0]   base_cnt,
    output logic [CNT_W-1:0]   count
);

    localparam logic [SYM_W-1:0] CODE = base_code(BASE_IDX);

    logic [SYMS-1:0] hit;
    logic [OFF_W:0]  pop;

    genvar j;
    generate
        for (j = 0; j < SYMS; j++) begin : g_sym
            assign hit[j] = (slice[j*SYM_W +: SYM_W] == CODE) &&
                            ((OFF_W+1)'(j) < {1'b0, offset});
        end
    endgenerate

    always_comb begin
        pop = '0;
        for (int n = 0; n < SYMS; n++) begin
            pop = pop + (OFF_W+1)'(hit[n]);
        end
        count = base_cnt + CNT_W'(pop);
    end

endmodule

// File: rtl/occ_blk_decoder.sv
module occ_blk_decoder
    import occ_lu_pkg::*;
#(
    parameter int CNT_W    = 40,
    parameter int SYMS     = 32,
    localparam int OFF_W   = $clog2(SYMS),
    localparam int SLICE_W = SYMS * SYM_W,
    localparam int BLK_W   = SLICE_W + N_BASE * CNT_W
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          dec_start,
    input  logic [BLK_W-1:0]              dec_blk,
    input  logic [OFF_W-1:0]              dec_off,
    output logic                          dec_finish,
    output logic [N_BASE-1:0][CNT_W-1:0]  dec_cnt
);

    typedef struct packed {
        logic [BLK_W-1:0]             blk;
        logic [OFF_W-1:0]             off;
        logic                         loaded;
        logic [N_BASE-1:0][CNT_W-1:0] cnt;
        logic                         fin;
    } dec_regs_t;

    dec_regs_t dec_d, dec_q;
    logic [N_BASE-1:0][CNT_W-1:0] cnt_w;

    genvar b;
    generate
        for (b = 0; b < N_BASE; b++) begin : g_base
            occ_base_counter #(
                .CNT_W    (CNT_W),
                .SYMS     (SYMS),
                .BASE_IDX (b)
            ) u_cnt (
                .slice    (dec_q.blk[BLK_W-1 -: SLICE_W]),
                .offset   (dec_q.off),
                .base_cnt (dec_q.blk[b*CNT_W +: CNT_W]),
                .count    (cnt_w[b])
            );
        end
    endgenerate

    always_comb begin
        dec_d        = dec_q;
        dec_d.loaded = dec_start;
        dec_d.fin    = dec_q.loaded;
        if (dec_start) begin
            dec_d.blk = dec_blk;
            dec_d.off = dec_off;
        end
        if (dec_q.loaded) begin
            dec_d.cnt = cnt_w;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) dec_q <= '0;
        else     dec_q <= dec_d;
    end

    assign dec_finish = dec_q.fin;
    assign dec_cnt    = dec_q.cnt;

endmodule

// File: rtl/occ_block_lookup.sv
module occ_block_lookup
    import occ_lu_pkg::*;
#(
    parameter int CNT_W    = 40,
    parameter int ADDR_W   = 40,
    parameter int SYMS     = 32,
    localparam int OFF_W   = $clog2(SYMS),
    localparam int BLK_W   = SYMS * SYM_W + N_BASE * CNT_W
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          start,
    input  logic [ADDR_W-1:0]             pos_k_in,
    input  logic [ADDR_W-1:0]             pos_ks_in,
    output logic                          busy,
    output logic                          occ_valid,
    output logic [N_BASE-1:0][CNT_W-1:0]  occ_k_out,
    output logic [N_BASE-1:0][CNT_W-1:0]  occ_ks_out,
    output logic                          ar_valid,
    input  logic                          ar_ready,
    output logic [ADDR_W-1:0]             ar_addr,
    input  logic                          r_valid,
    output logic                          r_ready,
    input  logic [BLK_W-1:0]              r_data
);

    typedef struct packed {
        lu_state_e                    st;
        logic [ADDR_W-1:0]            pos_k;
        logic [ADDR_W-1:0]            pos_ks;
        logic [1:0]                   req_cnt;
        logic [BLK_W-1:0]             blk2;
        logic [N_BASE-1:0][CNT_W-1:0] k_hold;
        logic [N_BASE-1:0][CNT_W-1:0] out_k;
        logic [N_BASE-1:0][CNT_W-1:0] out_ks;
        logic                         valid;
    } lu_regs_t;

    lu_regs_t lu_d, lu_q;

    logic                         dec_start;
    logic [BLK_W-1:0]             dec_blk;
    logic [OFF_W-1:0]             dec_off;
    logic                         dec_finish;
    logic [N_BASE-1:0][CNT_W-1:0] dec_cnt;
    logic                         ar_hs;
    logic                         r_hs;

    occ_blk_decoder #(
        .CNT_W (CNT_W),
        .SYMS  (SYMS)
    ) u_dec (
        .clk        (clk),
        .rst        (rst),
        .dec_start  (dec_start),
        .dec_blk    (dec_blk),
        .dec_off    (dec_off),
        .dec_finish (dec_finish),
        .dec_cnt    (dec_cnt)
    );

    function automatic logic [ADDR_W-1:0] blk_align(input logic [ADDR_W-1:0] p);
        logic [ADDR_W-1:0] a;
        a = p;
        a[OFF_W-1:0] = '0;
        return a;
    endfunction

    always_comb begin
        ar_valid = (lu_q.st != ST_IDLE) && (lu_q.st != ST_PREPARE) && (lu_q.req_cnt < 2'd2);
        ar_addr  = blk_align((lu_q.req_cnt == 2'd0) ? lu_q.pos_k : lu_q.pos_ks);
        r_ready  = (lu_q.st == ST_READ1) || (lu_q.st == ST_DEC1_RD2) || (lu_q.st == ST_WAIT_RD2);
        ar_hs    = ar_valid && ar_ready;
        r_hs     = r_valid && r_ready;
    end

    always_comb begin
        lu_d       = lu_q;
        lu_d.valid = 1'b0;
        dec_start  = 1'b0;
        dec_blk    = r_data;
        dec_off    = lu_q.pos_ks[OFF_W-1:0];

        if (ar_hs) begin
            lu_d.req_cnt = lu_q.req_cnt + 2'd1;
        end

        unique case (lu_q.st)
            ST_IDLE: begin
                if (start) begin
                    lu_d.pos_k   = pos_k_in;
                    lu_d.pos_ks  = pos_ks_in;
                    lu_d.req_cnt = '0;
                    lu_d.st      = ST_PREPARE;
                end
            end
            ST_PREPARE: begin
                lu_d.st = ST_READ1;
            end
            ST_READ1: begin
                if (r_hs) begin
                    dec_start = 1'b1;
                    dec_off   = lu_q.pos_k[OFF_W-1:0];
                    lu_d.st   = ST_DEC1_RD2;
                end
            end
            ST_DEC1_RD2: begin
                if (dec_finish) begin
                    lu_d.k_hold = dec_cnt;
                end
                if (r_hs) begin
                    lu_d.blk2 = r_data;
                end
                if (dec_finish && r_hs) begin
                    dec_start = 1'b1;
                    lu_d.st   = ST_DECOMP2;
                end else if (dec_finish) begin
                    lu_d.st = ST_WAIT_RD2;
                end else if (r_hs) begin
                    lu_d.st = ST_WAIT_DEC1;
                end
            end
            ST_WAIT_RD2: begin
                if (r_hs) begin
                    dec_start = 1'b1;
                    lu_d.st   = ST_DECOMP2;
                end
            end
            ST_WAIT_DEC1: begin
                if (dec_finish) begin
                    lu_d.k_hold = dec_cnt;
                    dec_start   = 1'b1;
                    dec_blk     = lu_q.blk2;
                    lu_d.st     = ST_DECOMP2;
                end
            end
            ST_DECOMP2: begin
                if (dec_finish) begin
                    lu_d.out_k  = lu_q.k_hold;
                    lu_d.out_ks = dec_cnt;
                    lu_d.valid  = 1'b1;
                    lu_d.st     = ST_IDLE;
                end
            end
            default: begin
                lu_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) lu_q <= '0;
        else     lu_q <= lu_d;
    end

    assign busy       = (lu_q.st != ST_IDLE);
    assign occ_valid  = lu_q.valid;
    assign occ_k_out  = lu_q.out_k;
    assign occ_ks_out = lu_q.out_ks;

endmodule

// File: rtl/occ_block_lookup_chk.sv
module occ_block_lookup_chk
    import occ_lu_pkg::*;
#(
    parameter int CNT_W  = 40,
    parameter int ADDR_W = 40
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          busy,
    input logic                          occ_valid,
    input logic [N_BASE-1:0][CNT_W-1:0]  occ_k_out,
    input logic [N_BASE-1:0][CNT_W-1:0]  occ_ks_out,
    input logic                          ar_valid,
    input logic                          ar_ready,
    input logic [ADDR_W-1:0]             ar_addr,
    input logic                          r_ready
);

    logic [1:0] req_seen_q;

    always_ff @(posedge clk) begin
        if (rst)                       req_seen_q <= '0;
        else if (occ_valid)            req_seen_q <= '0;
        else if (ar_valid && ar_ready) req_seen_q <= req_seen_q + 2'd1;
    end

    p_quiet_after_reset_r1: assert property (@(posedge clk)
        rst |=> (!busy && !occ_valid && !ar_valid && !r_ready));

    p_addr_aligned_r3: assert property (@(posedge clk) disable iff (rst)
        ar_valid |-> (ar_addr[4:0] == 5'd0));

    p_addr_held_r3: assert property (@(posedge clk) disable iff (rst)
        (ar_valid && !ar_ready) |=> (ar_valid && $stable(ar_addr)));

    p_valid_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        occ_valid |=> !occ_valid);

    p_valid_idle_r7: assert property (@(posedge clk) disable iff (rst)
        occ_valid |-> !busy);

    p_outputs_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !occ_valid |-> ($stable(occ_k_out) && $stable(occ_ks_out)));

    p_two_reads_r8: assert property (@(posedge clk) disable iff (rst)
        occ_valid |-> (req_seen_q == 2'd2));

    p_rready_busy_r10: assert property (@(posedge clk) disable iff (rst)
        r_ready |-> busy);

endmodule

bind occ_block_lookup occ_block_lookup_chk #(
    .CNT_W  (CNT_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy),
    .occ_valid  (occ_valid),
    .occ_k_out  (occ_k_out),
    .occ_ks_out (occ_ks_out),
    .ar_valid   (ar_valid),
    .ar_ready   (ar_ready),
    .ar_addr    (ar_addr),
    .r_ready    (r_ready)
);

// File: tb/occ_block_lookup_bench.sv
module occ_block_lookup_bench;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W  = 40;
    localparam int ADDR_W = 40;
    localparam int BLK_W  = 256;
    localparam int NBLK   = 8;
    localparam int NSYM   = NBLK * 32;

    logic                   clk = 1'b0;
    logic                   rst = 1'b1;
    logic                   start = 1'b0;
    logic [ADDR_W-1:0]      pos_k_in = '0;
    logic [ADDR_W-1:0]      pos_ks_in = '0;
    logic                   busy;
    logic                   occ_valid;
    logic [3:0][CNT_W-1:0]  occ_k_out;
    logic [3:0][CNT_W-1:0]  occ_ks_out;
    logic                   ar_valid;
    logic                   ar_ready = 1'b0;
    logic [ADDR_W-1:0]      ar_addr;
    logic                   r_valid = 1'b0;
    logic                   r_ready;
    logic [BLK_W-1:0]       r_data = '0;

    occ_block_lookup #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .SYMS(32)) u_occ_block_lookup (
        .clk(clk), .rst(rst), .start(start), .pos_k_in(pos_k_in), .pos_ks_in(pos_ks_in),
        .busy(busy), .occ_valid(occ_valid), .occ_k_out(occ_k_out), .occ_ks_out(occ_ks_out),
        .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_addr(ar_addr),
        .r_valid(r_valid), .r_ready(r_ready), .r_data(r_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;

    logic [2:0]       sym [NSYM];
    logic [CNT_W-1:0] base_tab [NBLK][4];

    // memory model state
    logic              ar_hs_seen = 1'b0;
    logic              r_hs_seen  = 1'b0;
    logic [ADDR_W-1:0] addr_seen  = '0;
    logic [ADDR_W-1:0] mq_addr [2];
    int                mq_wait [2];
    int                mq_n = 0;
    int                lat = 0;
    bit                stall = 1'b0;
    int                cyc = 0;
    int                n_ar = 0;
    logic [ADDR_W-1:0] cur_k = '0;
    logic [ADDR_W-1:0] cur_ks = '0;

    task automatic check(input string what, input logic [159:0] got, input logic [159:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", what, got, exp);
        end
    endtask

    function automatic int blk_of(input logic [ADDR_W-1:0] p);
        return int'((p >> 5) % NBLK);
    endfunction

    // R2: block built in the bench layout (counts low, symbol j at 160+3j)
    function automatic logic [BLK_W-1:0] mem_blk(input logic [ADDR_W-1:0] a);
        logic [BLK_W-1:0] r;
        int b;
        b = blk_of(a);
        r = '0;
        for (int c = 0; c < 4; c++) r[40*c +: 40] = base_tab[b][c];
        for (int j = 0; j < 32; j++) r[160 + 3*j +: 3] = sym[b*32 + j];
        return r;
    endfunction

    // R4/R5: base count plus matches (code 1cc) before the offset
    function automatic logic [159:0] exp_vec(input logic [ADDR_W-1:0] p);
        logic [3:0][CNT_W-1:0] v;
        int b;
        int off;
        b   = blk_of(p);
        off = int'(p % 32);
        for (int c = 0; c < 4; c++) begin
            v[c] = base_tab[b][c];
            for (int j = 0; j < off; j++)
                if (sym[b*32 + j] == (3'b100 | 3'(c))) v[c] = v[c] + 1;
        end
        return v;
    endfunction

    always @(posedge clk) begin
        ar_hs_seen <= ar_valid && ar_ready;
        r_hs_seen  <= r_valid && r_ready;
        addr_seen  <= ar_addr;
        cyc        <= cyc + 1;
    end

    always @(negedge clk) begin
        if (r_hs_seen && mq_n > 0) begin
            mq_addr[0] = mq_addr[1];
            mq_wait[0] = mq_wait[1];
            mq_n--;
        end
        for (int e = 0; e < 2; e++) if (e < mq_n && mq_wait[e] > 0) mq_wait[e]--;
        if (ar_hs_seen) begin
            // R3: order and alignment of requests
            check($sformatf("R3 request %0d address", n_ar), 160'(addr_seen),
                  160'(((n_ar == 0) ? cur_k : cur_ks) & ~40'h1F));
            n_ar++;
            if (mq_n < 2) begin
                mq_addr[mq_n] = addr_seen;
                mq_wait[mq_n] = lat;
                mq_n++;
            end
        end
        ar_ready = (mq_n < 2) && (!stall || cyc[0]);
        r_valid  = (mq_n > 0) && (mq_wait[0] == 0);
        r_data   = (mq_n > 0) ? mem_blk(mq_addr[0]) : '0;
    end

    task automatic run_query(input logic [ADDR_W-1:0] k, input logic [ADDR_W-1:0] ks,
                             input int l, input bit st, input bit junk);
        int waited;
        logic [159:0] last_k;
        logic [159:0] last_ks;
        @(negedge clk);
        lat = l; stall = st; n_ar = 0; cur_k = k; cur_ks = ks;
        start = 1'b1; pos_k_in = k; pos_ks_in = ks;
        @(negedge clk);
        start = 1'b0;
        waited = 0;
        while (!occ_valid && waited < 60) begin
            if (junk && waited == 1) begin
                start = 1'b1; pos_k_in = ~k; pos_ks_in = k ^ 40'h55;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            waited++;
        end
        start = 1'b0;
        if (!occ_valid) begin
            check("R7 valid pulse timeout", 160'(0), 160'(1));
            return;
        end
        check($sformatf("R2/R4/R5/R6 occ_k k=%h lat=%0d%s", k, l, junk ? " R9" : ""),
              occ_k_out, exp_vec(k));
        check($sformatf("R2/R4/R5/R6/R8 occ_ks ks=%h lat=%0d%s", ks, l, junk ? " R9" : ""),
              occ_ks_out, exp_vec(ks));
        check("R8 two reads per query", 160'(n_ar), 160'(2));
        last_k = occ_k_out; last_ks = occ_ks_out;
        @(negedge clk);
        check("R7 valid single cycle", 160'(occ_valid), 160'(0));
        check("R7 outputs held", {occ_k_out ^ last_k} | {occ_ks_out ^ last_ks}, 160'(0));
        check("R10 r_ready low when idle", 160'({busy, r_ready}), 160'(0));
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] lfsr;
        logic [CNT_W-1:0] run [4];
        lfsr = 32'h1234_5678;
        for (int n = 0; n < NSYM; n++) begin
            lfsr = lfsr * 32'd1103515245 + 32'd12345;
            sym[n] = lfsr[18:16];
        end
        sym[77] = 3'b001;   // one terminator symbol
        for (int j = 0; j < 32; j++) sym[96 + j] = 3'b110;  // a block of all G
        for (int c = 0; c < 4; c++) run[c] = 40'h80_0000_0000 + CNT_W'(c * 1000);
        for (int b = 0; b < NBLK; b++) begin
            for (int c = 0; c < 4; c++) base_tab[b][c] = run[c];
            for (int j = 0; j < 32; j++)
                for (int c = 0; c < 4; c++)
                    if (sym[b*32 + j] == (3'b100 | 3'(c))) run[c] = run[c] + 1;
        end

        repeat (3) @(negedge clk);
        check("R1 reset outputs", 160'({busy, occ_valid, ar_valid, r_ready}), 160'(0));
        rst = 1'b0;
        @(negedge clk);
        check("R1 idle after reset", 160'({busy, occ_valid, ar_valid, r_ready}), 160'(0));

        // R4 offset 0 and full-block edges, R5 terminator block
        run_query(40'd0, 40'd31, 0, 1'b0, 1'b0);
        run_query(40'd32, 40'd63, 3, 1'b1, 1'b0);
        run_query(40'd96, 40'd127, 1, 1'b0, 1'b0);
        run_query(40'd78, 40'd77, 2, 1'b0, 1'b0);

        // near-exhaustive sweep over every position, varied latency and stalls (R8)
        for (int k = 0; k < NSYM; k++) begin
            run_query(40'(k), 40'((k * 37 + 11) % NSYM), k % 4, k[2], (k % 16) == 5);
        end

        // R3: upper address bits carried through the 40-bit address
        run_query(40'hFF_FFFF_FFE5, 40'h80_0000_0020, 2, 1'b1, 1'b0);
        run_query(40'h12_3456_789F, 40'h00_0000_0001, 0, 1'b0, 1'b1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule